// File: doc/BRIEF.md
# One-Time-Programmable Security Register Program Controller

This block is the device-side command logic of a serial flash memory for programming a user security region that can be written only once. A host shifts in a frame over SPI mode 0: an opcode byte, a 24-bit address with the most significant bit first, and then data bytes. Inputs are sampled on rising SCK edges. The data bytes are staged in a shared 256-byte page buffer. When chip select is released, the block checks the frame. If the frame is valid, the block starts a programming cycle of fixed length. At the end of that cycle the staged bytes are copied into a 64-byte user region, and the region is then locked for good.

A host arms the write-enable latch with a one-byte write-enable command before it sends the program frame. During programming it polls the status command to see the busy flag. A frame that is rejected clears the write-enable latch and changes no byte of the region. The causes are a frame that ends too early, a frame that ends on a partial byte, and any attempt after the region is locked.

The SPI pins are oversampled by the system clock. The rest of the chip reads the region through a plain combinational read port. A lock flag shows whether the single permitted programming has taken place.

Top module: `otp_prog_ctrl`

## Requirements
- R1: After reset the busy flag and the write-enable latch are 0, the lock flag is 0, every region byte reads 0xFF, and `miso_oe` is 0.
- R2: Opcode 0x06 sets the write-enable latch, but only if chip select rises after exactly 8 bits and no programming is in progress. A longer frame leaves the latch unchanged.
- R3: Opcode 0x05 returns a status byte MSB first, starting after the opcode. Bit 0 is busy, bit 1 is the write-enable latch, and bits 7..2 are 0. The byte is reloaded with live values every 8 bits for as long as chip select stays low. `miso_oe` is 1 only while this byte is being shifted out.
- R4: Opcode 0x9B starts programming when three conditions hold. The latch must be 1 when chip select falls. The frame must carry at least 40 bits. The bit count must be a multiple of 8. Busy then stays 1 for PROG_CYCLES clocks. When busy clears, data byte k has been written to region offset (addr[5:0]+k) mod 64, all other offsets are unchanged, and the lock flag becomes 1. Address bits above bit 5 do not select the region offset.
- R5: A 0x9B frame with fewer than 40 bits aborts. The latch is cleared, busy stays 0, and the region is unchanged.
- R6: A 0x9B frame whose bit count is not a multiple of 8 aborts in the same way as R5.
- R7: A 0x9B frame sent while the lock flag is 1 aborts in the same way as R5. The region never changes again.
- R8: A 0x9B frame sent while the latch is 0 at the chip-select fall is ignored. Busy stays 0 and the region is unchanged.
- R9: When more than 64 data bytes are sent, the offset wraps within the region, and a later byte replaces an earlier byte at the same offset.
- R10: The write-enable latch reads 0 for the whole time busy is 1.
- R11: `miso_oe` stays 0 for the whole of a 0x9B frame.
- R12: While busy is 1, opcode 0x06 has no effect, and status reads still report busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | SPI serial clock, mode 0 |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host; valid when miso_oe is 1 |
| miso_oe | output | 1 | Output enable for miso; 0 means high impedance |
| region_addr | input | $clog2(REG_BYTES) | Byte offset for the region read port |
| region_data | output | 8 | Region byte at region_addr |
| otp_locked | output | 1 | 1 once the region has been programmed |

## Verification
The hardest situation to reach is the locked state, because only one programming cycle can ever succeed. The R7 abort, and the check that the region then stays frozen, come only after a complete write and a full wait on the busy flag. The bench therefore reaches this state through a directed sequence. It then applies reset to start a fresh region lifetime before each later valid or random case. Random cases choose the start address, the data length and the fault class (short frame, partial byte, latch not set, or valid frame), and a bench model predicts the region contents and status. Status reads are placed inside the busy window to check the busy flag and the latch together.

// File: rtl/otp_pkg.sv
package otp_pkg;
    // Command opcodes decoded by the controller
    localparam logic [7:0] OPC_PROG = 8'h9B;
    localparam logic [7:0] OPC_STAT = 8'h05;
    localparam logic [7:0] OPC_WREN = 8'h06;

    // Frame length checkpoints, in whole bytes
    localparam int BYTES_OPCODE = 1;
    localparam int BYTES_HEADER = 4;   // opcode plus three address bytes
    localparam int BYTES_MIN    = 5;   // header plus one data byte
endpackage

// File: rtl/otp_spi_rx.sv
module otp_spi_rx #(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 3,
    parameter int CNT_SAT     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sck,
    input  logic             cs_n,
    input  logic             mosi,
    output logic             frame_start,
    output logic             frame_end,
    output logic             sck_fall,
    output logic             byte_vld,
    output logic [7:0]       byte_dat,
    output logic [2:0]       bit_phase,
    output logic [CNT_W-1:0] byte_cnt
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sck_sr;
        logic [SYNC_STAGES-1:0] cs_sr;
        logic [SYNC_STAGES-1:0] mosi_sr;
        logic                   sck_prev;
        logic                   cs_prev;
        logic [7:0]             shift;
        logic [2:0]             phase;
        logic [CNT_W-1:0]       nbytes;
        logic                   vld;
        logic [7:0]             dat;
    } rx_t;

    rx_t rx_d, rx_q;

    logic sck_s, cs_s, mosi_s, sck_rise;

    assign sck_s  = rx_q.sck_sr[SYNC_STAGES-1];
    assign cs_s   = rx_q.cs_sr[SYNC_STAGES-1];
    assign mosi_s = rx_q.mosi_sr[SYNC_STAGES-1];

    assign sck_rise    = sck_s & ~rx_q.sck_prev & ~cs_s;
    assign sck_fall    = ~sck_s & rx_q.sck_prev & ~cs_s;
    assign frame_start = ~cs_s & rx_q.cs_prev;
    assign frame_end   = cs_s & ~rx_q.cs_prev;

    always_comb begin
        rx_d          = rx_q;
        rx_d.sck_sr   = {rx_q.sck_sr[SYNC_STAGES-2:0], sck};
        rx_d.cs_sr    = {rx_q.cs_sr[SYNC_STAGES-2:0], cs_n};
        rx_d.mosi_sr  = {rx_q.mosi_sr[SYNC_STAGES-2:0], mosi};
        rx_d.sck_prev = sck_s;
        rx_d.cs_prev  = cs_s;
        rx_d.vld      = 1'b0;
        if (frame_start) begin
            rx_d.phase  = '0;
            rx_d.nbytes = '0;
        end else if (sck_rise) begin
            rx_d.shift = {rx_q.shift[6:0], mosi_s};
            rx_d.phase = 3'(rx_q.phase + 3'd1);
            if (rx_q.phase == 3'd7) begin
                rx_d.vld = 1'b1;
                rx_d.dat = {rx_q.shift[6:0], mosi_s};
                if (rx_q.nbytes != CNT_W'(CNT_SAT)) begin
                    rx_d.nbytes = CNT_W'(rx_q.nbytes + 1'b1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q          <= '0;
            rx_q.cs_sr    <= '1;
            rx_q.cs_prev  <= 1'b1;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign byte_vld  = rx_q.vld;
    assign byte_dat  = rx_q.dat;
    assign bit_phase = rx_q.phase;
    assign byte_cnt  = rx_q.nbytes;

    AST_BYTE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_q.vld |-> (rx_q.phase == 3'd0)); // R6
endmodule

// File: rtl/otp_stage_buf.sv
module otp_stage_buf #(
    parameter int DEPTH = 256,
    parameter int WIN   = 64,
    parameter int AW    = $clog2(DEPTH),
    parameter int RAW   = $clog2(WIN),
    parameter int SW    = AW - RAW
) (
    input  logic                  clk,
    input  logic                  wr_en,
    input  logic [AW-1:0]         wr_addr,
    input  logic [7:0]            wr_data,
    input  logic [SW-1:0]         win_sel,
    output logic [WIN-1:0][7:0]   win_data
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // One read lane per region byte, taken from the selected window
    for (genvar i = 0; i < WIN; i++) begin : g_lane
        localparam logic [RAW-1:0] LANE = RAW'(i);
        assign win_data[i] = mem[{win_sel, LANE}];
    end
endmodule

// File: rtl/otp_region.sv
module otp_region #(
    parameter int BYTES = 64,
    parameter int AW    = $clog2(BYTES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  commit,
    input  logic [BYTES-1:0]      wmask,
    input  logic [BYTES-1:0][7:0] wdata,
    input  logic [AW-1:0]         rd_addr,
    output logic [7:0]            rd_data,
    output logic                  locked
);
    typedef struct packed {
        logic [BYTES-1:0][7:0] mem;
        logic                  lock;
    } reg_t;

    reg_t rg_d, rg_q;

    always_comb begin
        rg_d = rg_q;
        if (commit && !rg_q.lock) begin
            for (int i = 0; i < BYTES; i++) begin
                if (wmask[i]) begin
                    rg_d.mem[i] = wdata[i];
                end
            end
            rg_d.lock = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q.mem  <= '1;
            rg_q.lock <= 1'b0;
        end else begin
            rg_q <= rg_d;
        end
    end

    assign rd_data = rg_q.mem[rd_addr];
    assign locked  = rg_q.lock;

    AST_REGION_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        rg_q.lock |=> $stable(rg_q.mem)); // R7
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rg_q.lock |=> rg_q.lock); // R7
endmodule

// File: rtl/otp_prog_ctrl.sv
module otp_prog_ctrl
    import otp_pkg::*;
#(
    parameter int PROG_CYCLES = 4000,
    parameter int REG_BYTES   = 64,
    parameter int BUF_BYTES   = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sck,
    input  logic                         cs_n,
    input  logic                         mosi,
    output logic                         miso,
    output logic                         miso_oe,
    input  logic [$clog2(REG_BYTES)-1:0] region_addr,
    output logic [7:0]                   region_data,
    output logic                         otp_locked
);
    localparam int TW    = $clog2(PROG_CYCLES + 1);
    localparam int RAW   = $clog2(REG_BYTES);
    localparam int BAW   = $clog2(BUF_BYTES);
    localparam int SW    = BAW - RAW;
    localparam int CNT_W = 3;

    typedef struct packed {
        logic                 wel;
        logic                 busy;
        logic [TW-1:0]        timer;
        logic [7:0]           opc;
        logic                 wel_at;
        logic [BAW-1:0]       addr;
        logic [RAW-1:0]       ptr;
        logic [SW-1:0]        win;
        logic [REG_BYTES-1:0] mask;
        logic [7:0]           stat;
        logic                 oe;
    } ctl_t;

    ctl_t c_d, c_q;

    logic             frame_start, frame_end, sck_fall, byte_vld;
    logic [7:0]       byte_dat;
    logic [2:0]       bit_phase;
    logic [CNT_W-1:0] byte_cnt;

    logic                     buf_we;
    logic [BAW-1:0]           buf_wa;
    logic [REG_BYTES-1:0][7:0] win_data;
    logic                     commit;
    logic                     locked;
    logic                     accepted;
    logic [BAW-1:0]           addr_next;

    otp_spi_rx #(
        .SYNC_STAGES (SYNC_STAGES),
        .CNT_W       (CNT_W),
        .CNT_SAT     (BYTES_MIN)
    ) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .sck         (sck),
        .cs_n        (cs_n),
        .mosi        (mosi),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .sck_fall    (sck_fall),
        .byte_vld    (byte_vld),
        .byte_dat    (byte_dat),
        .bit_phase   (bit_phase),
        .byte_cnt    (byte_cnt)
    );

    otp_stage_buf #(
        .DEPTH (BUF_BYTES),
        .WIN   (REG_BYTES)
    ) u_buf (
        .clk      (clk),
        .wr_en    (buf_we),
        .wr_addr  (buf_wa),
        .wr_data  (byte_dat),
        .win_sel  (c_q.win),
        .win_data (win_data)
    );

    otp_region #(
        .BYTES (REG_BYTES)
    ) u_region (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (commit),
        .wmask   (c_q.mask),
        .wdata   (win_data),
        .rd_addr (region_addr),
        .rd_data (region_data),
        .locked  (locked)
    );

    assign accepted  = (c_q.opc == OPC_PROG) && c_q.wel_at && !c_q.busy;
    assign addr_next = BAW'({c_q.addr, byte_dat});

    always_comb begin
        c_d    = c_q;
        buf_we = 1'b0;
        buf_wa = '0;
        commit = 1'b0;

        // Programming timer: busy lasts exactly PROG_CYCLES clocks
        if (c_q.busy) begin
            if (c_q.timer == TW'(PROG_CYCLES - 1)) begin
                c_d.busy  = 1'b0;
                c_d.timer = '0;
                commit    = 1'b1;
            end else begin
                c_d.timer = TW'(c_q.timer + 1'b1);
            end
        end

        if (frame_start) begin
            c_d.opc    = '0;
            c_d.wel_at = c_q.wel;
            c_d.oe     = 1'b0;
        end

        // Byte-level decode of the incoming frame
        if (byte_vld) begin
            if (byte_cnt == CNT_W'(BYTES_OPCODE)) begin
                c_d.opc = byte_dat;
            end else if (accepted) begin
                if (byte_cnt <= CNT_W'(BYTES_HEADER)) begin
                    c_d.addr = addr_next;
                    if (byte_cnt == CNT_W'(BYTES_HEADER)) begin
                        c_d.ptr  = addr_next[RAW-1:0];
                        c_d.win  = addr_next[BAW-1:RAW];
                        c_d.mask = '0;
                    end
                end else begin
                    buf_we          = 1'b1;
                    buf_wa          = {c_q.win, c_q.ptr};
                    c_d.mask[c_q.ptr] = 1'b1;
                    c_d.ptr         = RAW'(c_q.ptr + 1'b1);
                end
            end
        end

        // Status shifter: reload on each byte boundary, shift otherwise
        if (sck_fall) begin
            if (bit_phase == 3'd0 && byte_cnt != '0 && c_q.opc == OPC_STAT) begin
                c_d.stat = {6'b0, c_q.wel, c_q.busy};
                c_d.oe   = 1'b1;
            end else if (c_q.oe) begin
                c_d.stat = {c_q.stat[6:0], 1'b0};
            end
        end

        // End-of-frame checks
        if (frame_end) begin
            c_d.oe = 1'b0;
            if (c_q.opc == OPC_WREN && !c_q.busy &&
                byte_cnt == CNT_W'(BYTES_OPCODE) && bit_phase == 3'd0) begin
                c_d.wel = 1'b1;
            end else if (accepted) begin
                c_d.wel = 1'b0;
                if (bit_phase == 3'd0 && byte_cnt == CNT_W'(BYTES_MIN) && !locked) begin
                    c_d.busy  = 1'b1;
                    c_d.timer = '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign miso       = c_q.oe & c_q.stat[7];
    assign miso_oe    = c_q.oe;
    assign otp_locked = locked;

    AST_OE_STATUS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.oe |-> (c_q.opc == OPC_STAT)); // R11
    AST_BUSY_WEL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.busy |-> !c_q.wel); // R10
    AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.busy |-> (c_q.timer < TW'(PROG_CYCLES))); // R4
    AST_LOCK_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(c_q.busy) |-> locked); // R4
    AST_NO_START_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(c_q.busy) |-> !$past(locked)); // R7
endmodule

// File: tb/tb_otp_prog_ctrl.sv
`timescale 1ns/1ps
module tb_otp_prog_ctrl;
    localparam int PROG = 3000;
    localparam int HALF = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0;
    logic       cs_n = 1'b1;
    logic       mosi = 1'b0;
    logic       miso, miso_oe, otp_locked;
    logic [5:0] region_addr = '0;
    logic [7:0] region_data;

    int n_checks = 0;
    int n_err    = 0;

    bit          txq[$];
    bit          rxq[$];
    bit          oe_seen;
    logic [7:0]  model [64];
    bit          locked_m;

    always #2.5 clk = ~clk;

    otp_prog_ctrl #(.PROG_CYCLES(PROG)) dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .miso_oe(miso_oe), .region_addr(region_addr),
        .region_data(region_data), .otp_locked(otp_locked)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic push_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) txq.push_back(b[i]);
    endtask

    task automatic run_frame(input int nbits);
        rxq.delete();
        oe_seen = 1'b0;
        @(negedge clk); cs_n = 1'b0;
        tick(HALF);
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            sck  = 1'b0;
            mosi = (i < txq.size()) ? txq[i] : 1'b0;
            if (miso_oe) oe_seen = 1'b1;
            tick(HALF);
            @(negedge clk);
            rxq.push_back(miso);
            if (miso_oe) oe_seen = 1'b1;
            sck = 1'b1;
            tick(HALF);
        end
        @(negedge clk); sck = 1'b0;
        tick(HALF);
        @(negedge clk); cs_n = 1'b1;
        tick(HALF + 4);
    endtask

    task automatic read_status(output logic [7:0] s0, output logic [7:0] s1,
                               output bit oe);
        txq.delete();
        push_byte(8'h05);
        push_byte(8'hA5);
        push_byte(8'h3C);
        run_frame(24);
        oe = oe_seen;
        for (int i = 0; i < 8; i++) begin
            s0[7-i] = rxq[8+i];
            s1[7-i] = rxq[16+i];
        end
    endtask

    task automatic status_is(input string req, input int exp);
        logic [7:0] s0, s1;
        bit oe;
        read_status(s0, s1, oe);
        check(req, s0, exp);
    endtask

    task automatic wren(input int nbits);
        txq.delete();
        push_byte(8'h06);
        push_byte(8'h00);
        run_frame(nbits);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        tick(4);
        @(negedge clk); rst_n = 1'b1;
        tick(4);
        for (int i = 0; i < 64; i++) model[i] = 8'hFF;
        locked_m = 1'b0;
    endtask

    task automatic check_region(input string req);
        int bad = 0;
        int first_i = 0;
        int first_a = 0;
        int first_e = 0;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            region_addr = 6'(i);
            #1;
            if (region_data !== model[i]) begin
                if (bad == 0) begin
                    first_i = i; first_a = region_data; first_e = model[i];
                end
                bad++;
            end
        end
        if (bad != 0) $display("  region offset %0d mismatch (%0d bytes)", first_i, bad);
        check(req, first_a, first_e);
        check({req, " lock"}, otp_locked, locked_m);
    endtask

    // One program attempt; nbits of the frame are sent
    task automatic attempt(input int addr, input int ndata, input int nbits,
                           input bit wen, input string req);
        logic [7:0] data[$];
        bit valid;
        int sent;
        if (wen) wren(8);
        txq.delete();
        push_byte(8'h9B);
        push_byte(addr[23:16]);
        push_byte(addr[15:8]);
        push_byte(addr[7:0]);
        for (int k = 0; k < ndata; k++) begin
            logic [7:0] b;
            b = 8'($urandom);
            data.push_back(b);
            push_byte(b);
        end
        run_frame(nbits);
        check({req, " R11 oe during program frame"}, oe_seen, 0);
        valid = wen && !locked_m && (nbits % 8 == 0) && (nbits >= 40);
        if (valid) begin
            sent = (nbits - 32) / 8;
            for (int k = 0; k < sent; k++) model[(addr + k) % 64] = data[k];
            status_is({req, " R10 busy with latch low"}, 8'h01);
            check({req, " R4 no lock while busy"}, otp_locked, 0);
            wren(8);
            status_is({req, " R12 write enable ignored while busy"}, 8'h01);
            tick(PROG);
            locked_m = 1'b1;
            status_is({req, " R4 idle after program"}, 8'h00);
        end else begin
            status_is({req, " no programming, latch clear"}, 8'h00);
        end
        check_region(req);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        logic [7:0] s0, s1;
        bit oe;
        void'($urandom(32'h0C0FFEE5));
        do_reset();

        // R1 reset state
        check("R1 miso_oe after reset", miso_oe, 0);
        check_region("R1 erased region");
        read_status(s0, s1, oe);
        check("R1 status after reset", s0, 8'h00);
        check("R3 status drives miso_oe", oe, 1);

        // R2 / R3 write enable and status encoding, repeat with live value
        wren(16);
        status_is("R2 long write-enable frame ignored", 8'h00);
        wren(8);
        read_status(s0, s1, oe);
        check("R2 latch set, R3 bit1", s0, 8'h02);
        check("R3 repeated status byte", s1, 8'h02);

        // R8 latch not set
        do_reset();
        attempt(32'h000010, 2, 48, 1'b0, "R8 latch not set");

        // R5 short frames
        attempt(32'h000000, 0, 32, 1'b1, "R5 address only");
        attempt(32'h000000, 0, 24, 1'b1, "R5 truncated address");
        // R6 partial byte
        attempt(32'h000004, 2, 44, 1'b1, "R6 partial byte");

        // R4 valid with wrap across the top offset, then R7 second attempt
        attempt(32'hFFFF3C, 6, 80, 1'b1, "R4 valid program");
        attempt(32'h000000, 3, 56, 1'b1, "R7 locked second attempt");

        // R9 more than 64 data bytes
        do_reset();
        attempt(32'h000010, 70, 32 + 70 * 8, 1'b1, "R9 wrap overwrite");

        // Random mix
        for (int it = 0; it < 6; it++) begin
            int kind, nd, addr, nbits;
            do_reset();
            kind = $urandom_range(0, 3);
            nd   = $urandom_range(1, 20);
            addr = int'($urandom & 32'h00FFFFFF);
            case (kind)
                0: attempt(addr, nd, 32 + nd * 8, 1'b1, "R4 random valid");
                1: attempt(addr, nd, $urandom_range(8, 39), 1'b1, "R5 random short");
                2: attempt(addr, nd, 32 + nd * 8 + $urandom_range(1, 7), 1'b1, "R6 random partial");
                default: attempt(addr, nd, 32 + nd * 8, 1'b0, "R8 random no latch");
            endcase
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule